// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a ring of transmit buffer descriptors held in system memory and turns them into frames on a byte stream. A host places 8-byte descriptors in memory and marks them ready. It then pulses a kick input while the controller enable input is high. The walker reads each descriptor through a 32-bit memory port that uses a valid/ready handshake. It copies the referenced payload into an internal frame store and hands the descriptor back to software by clearing its ready flag in memory. A frame may be spread over several descriptors. The frame is sent only when a descriptor flagged as last in frame has been copied.

The ring has a programmable base. Descriptors normally follow each other at 8-byte steps. A wrap flag in a descriptor sends the walker back to the base. The walk stops at the first descriptor that is not ready, and the position is kept for the next kick. A frame that would grow past the frame store is truncated, and the walker reports a babble event. Three one-cycle event pulses report progress: one per processed descriptor, one per completed frame, and one per truncation.

Top module: `tx_ring_walker`

## Requirements
- R1: After reset the walker is idle. `busy`, `mem_valid`, `tx_valid` and all event outputs are low, and while idle it makes no memory request and drives no stream byte.
- R2: A kick while `ctrl_enable` is low has no effect: no memory access, no stream output, and the descriptor in memory is unchanged. A kick that arrives while the walker is busy is also ignored.
- R3: A descriptor is two 32-bit words. The word at the descriptor address holds the flags in bits 15:0 (ready = bit 15, wrap = bit 13, last = bit 11) and the byte length in bits 31:16. The word at address + 4 holds the byte address of the buffer. Payload bytes are taken little-endian from word-aligned reads (byte address A is lane A[1:0] of the word at A with the low two bits cleared), for any buffer alignment. Every memory address the walker issues is word-aligned.
- R4: The walk stops at the first descriptor whose ready bit is clear. That descriptor is not written, and the next kick resumes from it.
- R5: After a descriptor is processed, the next one is read at address + 8. If the wrap bit of the descriptor is set, the next one is read at the ring base.
- R6: A write to the ring base stores the written value with its low two bits forced to zero, moves the current pointer to that base, and discards any partly assembled frame.
- R7: Payloads of consecutive ready descriptors are joined into one frame. After the last-flagged descriptor has been copied, the frame goes out on `tx_data` one byte per cycle in memory order, with `tx_last` on the final byte. No memory request is made while the frame is being sent.
- R8: If the bytes already held plus a descriptor's length would exceed MAX_FRAME (default 2048), only the remaining room is copied, and `ev_babble` pulses for that descriptor.
- R9: Each processed descriptor has its first word written back with only the ready bit cleared, and `ev_tx_buf` pulses. `ev_tx_frame` pulses together with it for a last-flagged descriptor.
- R10: A memory request keeps its address, direction and write data unchanged until `mem_ready` is seen high.
- R11: A frame left incomplete when a walk stops stays in the frame store. It is continued by the descriptors processed on a later kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_enable | input | 1 | Controller enable; kicks are accepted only while high |
| kick | input | 1 | One-cycle request to walk the ring |
| base_wr | input | 1 | Write strobe for the ring base |
| base_wdata | input | ADDR_W | Ring base value (low two bits dropped) |
| busy | output | 1 | High while a walk is in progress |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data (descriptor write-back) |
| mem_ready | input | 1 | Memory accepts the request; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| ev_tx_buf | output | 1 | Pulse: a descriptor was processed |
| ev_tx_frame | output | 1 | Pulse: a frame was completed |
| ev_babble | output | 1 | Pulse: the descriptor was truncated at the frame limit |

## Verification
The bench builds rings with chained buffers at every byte alignment. A walker that picked the wrong lane or refetched at the wrong point would send bytes shifted or repeated. It checks that a walk stops at a descriptor that is not ready, and then makes that descriptor ready to confirm the half-built frame carries on from the stored pointer. A design that lost the pointer or the frame would restart at the base or send a short frame. It also covers the wrap flag, a ring base written with dirty low bits, a kick with the enable low, and a frame pushed past the limit while memory stalls. Getting any of these wrong shows up as a misplaced read, a stray or missing frame, a byte count other than the cap, or a missing babble pulse.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
   localparam int FLAG_READY_BIT = 15;
   localparam int FLAG_WRAP_BIT  = 13;
   localparam int FLAG_LAST_BIT  = 11;
   localparam int DESC_STRIDE    = 8;
   localparam int PTR_OFFSET     = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HEAD,
      ST_PTR,
      ST_FETCH,
      ST_COPY,
      ST_EMIT,
      ST_BACK
   } walk_state_t;

   typedef struct packed {
      logic [15:0] len;
      logic [15:0] flags;
   } desc_head_t;
endpackage

// File: rtl/tdw_len_clamp.sv
module tdw_len_clamp #(
   parameter int MAX_FRAME = 2048,
   parameter int ACC_W     = 12,
   parameter int LEN_W     = 16
)(
   input  logic [ACC_W-1:0] held,
   input  logic [LEN_W-1:0] want,
   output logic [LEN_W-1:0] take,
   output logic             over
);
   localparam int SUM_W = ((ACC_W > LEN_W) ? ACC_W : LEN_W) + 1;

   logic [SUM_W-1:0] room;
   logic [SUM_W-1:0] want_x;

   always_comb begin
      room   = SUM_W'(MAX_FRAME) - SUM_W'(held);
      want_x = SUM_W'(want);
      over   = want_x > room;
      take   = over ? LEN_W'(room) : want;
   end
endmodule

// File: rtl/tdw_lane_pick.sv
module tdw_lane_pick #(
   parameter int WORD_W      = 32,
   parameter bit LANE_LITTLE = 1'b1
)(
   input  logic [WORD_W-1:0]                 word,
   input  logic [$clog2(WORD_W/8)-1:0]       lane,
   output logic [7:0]                        byte_out
);
   localparam int LANES = WORD_W / 8;

   generate
      if (LANE_LITTLE) begin : g_little
         assign byte_out = word[lane*8 +: 8];
      end else begin : g_big
         logic [$clog2(LANES)-1:0] flip;
         assign flip     = ($clog2(LANES))'(LANES - 1) - lane;
         assign byte_out = word[flip*8 +: 8];
      end
   endgenerate
endmodule

// File: rtl/tdw_frame_store.sv
module tdw_frame_store #(
   parameter int DEPTH = 2048,
   parameter int IDX_W = 11
)(
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [7:0]       wdata,
   input  logic [IDX_W-1:0] raddr,
   output logic [7:0]       rdata
);
   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker
   import tdw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int MAX_FRAME   = 2048,
   parameter bit LANE_LITTLE = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_enable,
   input  logic              kick,
   input  logic              base_wr,
   input  logic [ADDR_W-1:0] base_wdata,
   output logic              busy,
   output logic              mem_valid,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ready,
   input  logic [31:0]       mem_rdata,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   output logic              ev_tx_buf,
   output logic              ev_tx_frame,
   output logic              ev_babble
);
   localparam int WORD_W = 32;
   localparam int LEN_W  = 16;
   localparam int ACC_W  = $clog2(MAX_FRAME + 1);
   localparam int IDX_W  = $clog2(MAX_FRAME);
   localparam logic [ADDR_W-1:0] STRIDE     = ADDR_W'(DESC_STRIDE);
   localparam logic [ADDR_W-1:0] PTR_OFS    = ADDR_W'(PTR_OFFSET);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

   generate
      if (MAX_FRAME < 2 || MAX_FRAME > 65535) begin : g_bad_max
         $error("tx_ring_walker: MAX_FRAME must lie in 2..65535");
      end
      if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_addr
         $error("tx_ring_walker: ADDR_W must lie in 3..32");
      end
   endgenerate

   walk_state_t       state;
   logic [ADDR_W-1:0] cur_ptr;
   logic [ADDR_W-1:0] base_q;
   desc_head_t        head_q;
   desc_head_t        wb_head;
   logic [ADDR_W-1:0] baddr_q;
   logic [WORD_W-1:0] word_q;
   logic [LEN_W-1:0]  rem_q;
   logic [ACC_W-1:0]  acc_q;
   logic [ACC_W-1:0]  rd_q;
   logic              babble_q;

   logic              hs;
   logic              frame_end;
   logic              wrap_set;
   logic              emit_last;
   logic [LEN_W-1:0]  take_len;
   logic              take_over;
   logic [7:0]        lane_byte;
   logic              store_we;

   assign hs        = mem_valid && mem_ready;
   assign frame_end = head_q.flags[FLAG_LAST_BIT];
   assign wrap_set  = head_q.flags[FLAG_WRAP_BIT];
   assign busy      = (state != ST_IDLE);
   assign store_we  = (state == ST_COPY);
   assign tx_valid  = (state == ST_EMIT);
   assign emit_last = (rd_q == acc_q - ACC_W'(1));
   assign tx_last   = tx_valid && emit_last;

   tdw_len_clamp #(
      .MAX_FRAME(MAX_FRAME),
      .ACC_W    (ACC_W),
      .LEN_W    (LEN_W)
   ) i_clamp (
      .held(acc_q),
      .want(head_q.len),
      .take(take_len),
      .over(take_over)
   );

   tdw_lane_pick #(
      .WORD_W     (WORD_W),
      .LANE_LITTLE(LANE_LITTLE)
   ) i_lane (
      .word    (word_q),
      .lane    (baddr_q[1:0]),
      .byte_out(lane_byte)
   );

   tdw_frame_store #(
      .DEPTH(MAX_FRAME),
      .IDX_W(IDX_W)
   ) i_store (
      .clk  (clk),
      .we   (store_we),
      .waddr(acc_q[IDX_W-1:0]),
      .wdata(lane_byte),
      .raddr(rd_q[IDX_W-1:0]),
      .rdata(tx_data)
   );

   always_comb begin
      wb_head                       = head_q;
      wb_head.flags[FLAG_READY_BIT] = 1'b0;
      mem_valid = 1'b0;
      mem_write = 1'b0;
      mem_addr  = cur_ptr;
      mem_wdata = '0;
      unique case (state)
         ST_HEAD: begin
            mem_valid = 1'b1;
         end
         ST_PTR: begin
            mem_valid = 1'b1;
            mem_addr  = cur_ptr + PTR_OFS;
         end
         ST_FETCH: begin
            mem_valid = 1'b1;
            mem_addr  = baddr_q & ALIGN_MASK;
         end
         ST_BACK: begin
            mem_valid = 1'b1;
            mem_write = 1'b1;
            mem_wdata = wb_head;
         end
         default: begin
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cur_ptr     <= '0;
         base_q      <= '0;
         head_q      <= '0;
         baddr_q     <= '0;
         word_q      <= '0;
         rem_q       <= '0;
         acc_q       <= '0;
         rd_q        <= '0;
         babble_q    <= 1'b0;
         ev_tx_buf   <= 1'b0;
         ev_tx_frame <= 1'b0;
         ev_babble   <= 1'b0;
      end else begin
         ev_tx_buf   <= 1'b0;
         ev_tx_frame <= 1'b0;
         ev_babble   <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (kick && ctrl_enable) begin
                  state <= ST_HEAD;
               end
            end
            ST_HEAD: begin
               if (hs) begin
                  head_q <= mem_rdata;
                  state  <= mem_rdata[FLAG_READY_BIT] ? ST_PTR : ST_IDLE;
               end
            end
            ST_PTR: begin
               if (hs) begin
                  baddr_q  <= mem_rdata[ADDR_W-1:0];
                  rem_q    <= take_len;
                  babble_q <= take_over;
                  rd_q     <= '0;
                  if (take_len != '0) begin
                     state <= ST_FETCH;
                  end else if (frame_end && acc_q != '0) begin
                     state <= ST_EMIT;
                  end else begin
                     state <= ST_BACK;
                  end
               end
            end
            ST_FETCH: begin
               if (hs) begin
                  word_q <= mem_rdata;
                  state  <= ST_COPY;
               end
            end
            ST_COPY: begin
               acc_q   <= acc_q + ACC_W'(1);
               baddr_q <= baddr_q + ADDR_W'(1);
               rem_q   <= rem_q - LEN_W'(1);
               if (rem_q == LEN_W'(1)) begin
                  state <= frame_end ? ST_EMIT : ST_BACK;
               end else if (baddr_q[1:0] == 2'b11) begin
                  state <= ST_FETCH;
               end
            end
            ST_EMIT: begin
               rd_q <= rd_q + ACC_W'(1);
               if (emit_last) begin
                  state <= ST_BACK;
               end
            end
            ST_BACK: begin
               if (hs) begin
                  ev_tx_buf   <= 1'b1;
                  ev_tx_frame <= frame_end;
                  ev_babble   <= babble_q;
                  if (frame_end) begin
                     acc_q <= '0;
                  end
                  cur_ptr <= wrap_set ? base_q : cur_ptr + STRIDE;
                  state   <= ST_HEAD;
               end
            end
            default: state <= ST_IDLE;
         endcase
         if (base_wr) begin
            base_q  <= base_wdata & ALIGN_MASK;
            cur_ptr <= base_wdata & ALIGN_MASK;
            acc_q   <= '0;
         end
      end
   end
endmodule

// File: rtl/tdw_checker.sv
module tdw_checker #(
   parameter int ADDR_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              ctrl_enable,
   input logic              kick,
   input logic              busy,
   input logic              mem_valid,
   input logic              mem_write,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic              mem_ready,
   input logic              tx_valid,
   input logic              tx_last,
   input logic              ev_tx_buf,
   input logic              ev_tx_frame,
   input logic              ev_babble
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_valid && !tx_valid));

   assert_kick_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (kick && !ctrl_enable && !busy) |=> !busy);

   assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_addr[1:0] == 2'b00));

   assert_last_in_stream_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   assert_no_mem_while_emit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !mem_valid);

   assert_wb_ready_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write) |-> !mem_wdata[15]);

   assert_events_paired_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_tx_frame || ev_babble) |-> ev_tx_buf);

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=>
         (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));
endmodule

bind tx_ring_walker tdw_checker #(.ADDR_W(ADDR_W)) i_tdw_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctrl_enable(ctrl_enable),
   .kick       (kick),
   .busy       (busy),
   .mem_valid  (mem_valid),
   .mem_write  (mem_write),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_ready  (mem_ready),
   .tx_valid   (tx_valid),
   .tx_last    (tx_last),
   .ev_tx_buf  (ev_tx_buf),
   .ev_tx_frame(ev_tx_frame),
   .ev_babble  (ev_babble)
);

// File: tb/test_tx_ring_walker.sv
module test_tx_ring_walker;
   localparam int CLK_PERIOD = 10;
   localparam int MAXF = 2048;
   localparam logic [15:0] RDY = 16'h8000;
   localparam logic [15:0] WRP = 16'h2000;
   localparam logic [15:0] LST = 16'h0800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_enable = 1'b0;
   logic        kick = 1'b0;
   logic        base_wr = 1'b0;
   logic [31:0] base_wdata = '0;
   logic        busy, mem_valid, mem_write, mem_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        tx_valid, tx_last, ev_tx_buf, ev_tx_frame, ev_babble;
   logic [7:0]  tx_data;

   logic [31:0] mem [0:1023];
   logic [1:0]  cyc = 2'b00;
   logic        stall_mode = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   int n_txb = 0, n_txf = 0, n_bab = 0, n_mem = 0, n_bytes = 0;

   logic [8:0] exp_q [$];
   logic [7:0] frame_acc [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   tx_ring_walker i_tx_ring_walker (
      .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable), .kick(kick),
      .base_wr(base_wr), .base_wdata(base_wdata), .busy(busy),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
      .ev_tx_buf(ev_tx_buf), .ev_tx_frame(ev_tx_frame), .ev_babble(ev_babble)
   );

   assign mem_ready = !stall_mode || (cyc == 2'b11);
   assign mem_rdata = mem[mem_addr[11:2]];

   always @(posedge clk) begin
      cyc <= cyc + 2'b01;
      if (mem_valid && mem_ready && mem_write) mem[mem_addr[11:2]] <= mem_wdata;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      logic [8:0] e;
      if (rst_n) begin
         if (ev_tx_buf) n_txb++;
         if (ev_tx_frame) n_txf++;
         if (ev_babble) n_bab++;
         if (mem_valid) n_mem++;
         if (tx_valid) begin
            n_bytes++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 unexpected stream byte", int'({tx_last, tx_data}), 0);
            end else begin
               e = exp_q.pop_front();
               check({tx_last, tx_data} == e, "R7 stream byte/last", int'({tx_last, tx_data}), int'(e));
            end
         end
      end
   end

   function automatic logic [7:0] get_byte(input int a);
      logic [31:0] w;
      w = mem[(a >> 2) & 1023];
      return w[(a & 3)*8 +: 8];
   endfunction

   task automatic set_byte(input int a, input logic [7:0] v);
      mem[(a >> 2) & 1023][(a & 3)*8 +: 8] = v;
   endtask

   task automatic fill(input int a, input int n, input int seed);
      for (int i = 0; i < n; i++) set_byte(a + i, 8'(seed + i * 13));
   endtask

   task automatic put_desc(input int a, input logic [15:0] fl, input logic [15:0] ln, input logic [31:0] ba);
      mem[a >> 2]       = {ln, fl};
      mem[(a >> 2) + 1] = ba;
   endtask

   // driver side: model the frame and push expected bytes
   task automatic exp_chunk(input int a, input int n);
      for (int i = 0; i < n; i++)
         if (frame_acc.size() < MAXF) frame_acc.push_back(get_byte(a + i));
   endtask

   task automatic exp_close();
      for (int i = 0; i < frame_acc.size(); i++)
         exp_q.push_back({(i == frame_acc.size() - 1), frame_acc[i]});
      frame_acc.delete();
   endtask

   task automatic write_base(input logic [31:0] v);
      @(negedge clk) begin base_wr = 1'b1; base_wdata = v; end
      @(negedge clk) base_wr = 1'b0;
      frame_acc.delete();
   endtask

   task automatic kick_walk();
      @(negedge clk) kick = 1'b1;
      @(negedge clk) kick = 1'b0;
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic check_wb(input int a, input logic [15:0] fl, input logic [15:0] ln, input logic [31:0] ba, input string tag);
      check(mem[a >> 2] == {ln, fl & 16'h7fff}, tag, int'(mem[a >> 2]), int'({ln, fl & 16'h7fff}));
      check(mem[(a >> 2) + 1] == ba, tag, int'(mem[(a >> 2) + 1]), int'(ba));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int txb0, txf0, bab0, mem0, byt0;
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!busy, "R1 busy after reset", busy, 0);
      check(!mem_valid, "R1 mem_valid after reset", mem_valid, 0);
      check(!tx_valid, "R1 tx_valid after reset", tx_valid, 0);
      check(!(ev_tx_buf | ev_tx_frame | ev_babble), "R1 events after reset",
            {ev_tx_buf, ev_tx_frame, ev_babble}, 0);

      // R2 kick with enable low is ignored
      write_base(32'h0);
      fill(32'h800, 4, 8'h11);
      put_desc(32'h000, RDY | LST, 16'd4, 32'h800);
      mem0 = n_mem; txb0 = n_txb; byt0 = n_bytes;
      kick_walk();
      repeat (10) @(negedge clk);
      check(n_mem == mem0, "R2 memory accesses on disabled kick", n_mem - mem0, 0);
      check(n_bytes == byt0, "R2 stream bytes on disabled kick", n_bytes - byt0, 0);
      check(n_txb == txb0, "R2 events on disabled kick", n_txb - txb0, 0);
      check(mem[0] == {16'd4, RDY | LST}, "R2 descriptor untouched", int'(mem[0]), int'({16'd4, RDY | LST}));

      // R9 single frame once enabled
      ctrl_enable = 1'b1;
      exp_chunk(32'h800, 4); exp_close();
      txb0 = n_txb; txf0 = n_txf;
      kick_walk();
      check(exp_q.size() == 0, "R9 single frame delivered", exp_q.size(), 0);
      check_wb(32'h000, RDY | LST, 16'd4, 32'h800, "R9 write-back single");
      check(n_txb - txb0 == 1, "R9 buffer events", n_txb - txb0, 1);
      check(n_txf - txf0 == 1, "R9 frame events", n_txf - txf0, 1);

      // R3 R7 chained buffers at odd alignments; R4 stop at not-ready
      fill(32'h801, 3, 8'h20); fill(32'h843, 6, 8'h40); fill(32'h862, 1, 8'h60);
      put_desc(32'h008, RDY, 16'd3, 32'h801);
      put_desc(32'h010, RDY, 16'd6, 32'h843);
      put_desc(32'h018, RDY | LST, 16'd1, 32'h862);
      put_desc(32'h020, 16'h0000, 16'd5, 32'h900);
      exp_chunk(32'h801, 3); exp_chunk(32'h843, 6); exp_chunk(32'h862, 1); exp_close();
      txb0 = n_txb; txf0 = n_txf;
      kick_walk();
      check(exp_q.size() == 0, "R3 chained frame delivered", exp_q.size(), 0);
      check(n_txb - txb0 == 3, "R7 buffer events for chain", n_txb - txb0, 3);
      check(n_txf - txf0 == 1, "R7 one frame for chain", n_txf - txf0, 1);
      check_wb(32'h010, RDY, 16'd6, 32'h843, "R9 write-back mid chain");
      check(mem[32'h20 >> 2] == {16'd5, 16'h0000}, "R4 not-ready descriptor untouched",
            int'(mem[32'h20 >> 2]), int'({16'd5, 16'h0000}));

      // R11 R4 partial frame resumes from the kept pointer
      fill(32'h900, 5, 8'h70); fill(32'h90a, 2, 8'h90);
      put_desc(32'h020, RDY, 16'd5, 32'h900);
      put_desc(32'h028, 16'h0000, 16'd2, 32'h90a);
      byt0 = n_bytes; txb0 = n_txb;
      kick_walk();
      check(n_bytes == byt0, "R11 no output before last", n_bytes - byt0, 0);
      check(n_txb - txb0 == 1, "R11 partial buffer event", n_txb - txb0, 1);
      put_desc(32'h028, RDY | LST, 16'd2, 32'h90a);
      exp_chunk(32'h900, 5); exp_chunk(32'h90a, 2); exp_close();
      kick_walk();
      check(exp_q.size() == 0, "R11 resumed frame delivered", exp_q.size(), 0);
      check(n_bytes - byt0 == 7, "R4 resumed byte count", n_bytes - byt0, 7);

      // R5 wrap flag returns to the base
      fill(32'h920, 3, 8'ha0); fill(32'h940, 2, 8'hb0);
      put_desc(32'h030, RDY | LST | WRP, 16'd3, 32'h920);
      put_desc(32'h000, RDY | LST, 16'd2, 32'h940);
      exp_chunk(32'h920, 3); exp_close(); exp_chunk(32'h940, 2); exp_close();
      txf0 = n_txf;
      kick_walk();
      check(exp_q.size() == 0, "R5 frames across wrap", exp_q.size(), 0);
      check(n_txf - txf0 == 2, "R5 frame events across wrap", n_txf - txf0, 2);
      check_wb(32'h000, RDY | LST, 16'd2, 32'h940, "R5 base descriptor written back");

      // R6 base write aligns, reloads pointer, drops partial frame
      fill(32'h980, 3, 8'hc0); fill(32'h960, 4, 8'hd0);
      put_desc(32'h008, RDY, 16'd3, 32'h980);
      kick_walk();
      put_desc(32'h100, RDY | LST, 16'd4, 32'h960);
      put_desc(32'h108, 16'h0000, 16'd1, 32'h960);
      write_base(32'h103);
      exp_chunk(32'h960, 4); exp_close();
      byt0 = n_bytes;
      kick_walk();
      check(exp_q.size() == 0, "R6 frame from aligned base", exp_q.size(), 0);
      check(n_bytes - byt0 == 4, "R6 partial frame discarded", n_bytes - byt0, 4);
      check_wb(32'h100, RDY | LST, 16'd4, 32'h960, "R6 write-back at aligned base");

      // R8 R10 babble cap under memory stalls
      stall_mode = 1'b1;
      fill(32'h400, 1500, 8'h05);
      write_base(32'h200);
      put_desc(32'h200, RDY, 16'd1500, 32'h400);
      put_desc(32'h208, RDY | LST, 16'd1000, 32'h400);
      put_desc(32'h210, 16'h0000, 16'd2, 32'h300);
      exp_chunk(32'h400, 1500); exp_chunk(32'h400, 1000); exp_close();
      bab0 = n_bab; byt0 = n_bytes; txf0 = n_txf;
      kick_walk();
      check(exp_q.size() == 0, "R8 capped frame delivered", exp_q.size(), 0);
      check(n_bytes - byt0 == MAXF, "R8 capped length", n_bytes - byt0, MAXF);
      check(n_bab - bab0 == 1, "R8 babble events", n_bab - bab0, 1);
      check(n_txf - txf0 == 1, "R10 frame under stalls", n_txf - txf0, 1);
      check_wb(32'h208, RDY | LST, 16'd1000, 32'h400, "R9 write-back keeps original length");

      // R8 following frame is not truncated
      stall_mode = 1'b0;
      fill(32'h300, 2, 8'he0);
      put_desc(32'h210, RDY | LST, 16'd2, 32'h300);
      exp_chunk(32'h300, 2); exp_close();
      bab0 = n_bab;
      kick_walk();
      check(exp_q.size() == 0, "R8 next frame delivered", exp_q.size(), 0);
      check(n_bab == bab0, "R8 no babble on short frame", n_bab - bab0, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule